// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block produces the bit clock and the periodic frame sync for a framed serial audio port. The bit clock comes either from an internal divider of the system clock or from rising edges seen on an external bit-clock input pin. Bit clocks are counted to form frames of programmable length, and a frame sync pulse of programmable width is raised at the start of each frame. Its polarity is selectable.

Two active-low controls gate the block. One holds the clock generator in reset and the other holds the frame sync generator in reset. Frame sync runs only while the clock generator runs. When the port is a slave, both pins are inputs: the output enables are low and the generator is idle. When the external clock option is chosen, the bit-clock pin stays an input and the frame sync is still produced internally. All configuration arrives as parallel inputs. The register bus and the data shifting belong elsewhere.

Top module: `frame_sync_gen`

## Requirements
- R1: With `master`=0, `bclk_oe` and `fs_oe` are 0, `bclk_out` is 0 and `fs_out` sits at its inactive level, whatever the two reset controls hold. With `master`=1 and `ext_clk_sel`=0, both output enables are 1.
- R2: In internal clock mode with `clk_div`=N (N>=1), `bclk_out` has a period of N+1 clock cycles and is high for floor((N+1)/2) cycles of each period.
- R3: With the frame sync running, the interval between successive frame sync assertions is (`frame_per`+1) bit clocks.
- R4: The frame sync becomes active at bit 0 of each frame and stays active for (`sync_wid`+1) bit clocks. This needs `sync_wid` < `frame_per`.
- R5: `fs_low`=1 makes the frame sync active-low (`fs_out`=0 while active, 1 while idle). `fs_low`=0 makes it active-high.
- R6: While `gen_rst_n`=0, `bclk_out` stays 0 and the frame sync stays inactive, even if `fs_rst_n`=1.
- R7: While `fs_rst_n`=0 with the clock generator running, the bit clock keeps toggling and the frame sync stays inactive. When `fs_rst_n` returns to 1, the frame sync is active in that same cycle (frame restarts at bit 0).
- R8: With `ext_clk_sel`=1, each rising edge on `ext_bclk_in` counts as one bit clock. `bclk_oe` and `bclk_out` are 0, `fs_oe` stays 1, and frame timing follows R3 and R4 in units of external periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1: block drives clock and sync pins; 0: slave, pins are inputs |
| ext_clk_sel | input | 1 | 1: bit clock taken from `ext_bclk_in` |
| ext_bclk_in | input | 1 | External bit clock pin (asynchronous) |
| clk_div | input | DIV_W | Internal divider N, bit clock = clk/(N+1) |
| frame_per | input | CNT_W | Frame length in bit clocks, minus one |
| sync_wid | input | CNT_W | Frame sync width in bit clocks, minus one |
| fs_low | input | 1 | Frame sync polarity, 1 = active-low |
| gen_rst_n | input | 1 | Clock generator reset control, active low |
| fs_rst_n | input | 1 | Frame sync generator reset control, active low |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Output enable for the bit-clock pin |
| fs_out | output | 1 | Frame sync |
| fs_oe | output | 1 | Output enable for the frame sync pin |

## Verification
A divider counter that wraps at the wrong value shows up on `bclk_out` within one bit period as a wrong high time or period. A frame counter that is off shows up within one frame as a sync interval or width that differs from the programmed count by a multiple of the bit period. A counter that is not cleared by a reset control shows up at the first cycle after release. The sync must then be active at once, and the first measured frame after a restart must already be full length. The bench measures intervals in system clock cycles at the pins, so any error in divider, wrap or width decoding changes a measured count within the first full frame.

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             ext_clk_sel,
  input  logic             ext_bclk_in,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [CNT_W-1:0] frame_per,
  input  logic [CNT_W-1:0] sync_wid,
  input  logic             fs_low,
  input  logic             gen_rst_n,
  input  logic             fs_rst_n,
  output logic             bclk_out,
  output logic             bclk_oe,
  output logic             fs_out,
  output logic             fs_oe
);

  localparam int HW = DIV_W + 1;

  logic [DIV_W-1:0] dcnt;
  logic [CNT_W-1:0] bcnt;
  logic [2:0]       xsync;
  logic             gen_run, fs_run, div_end, ext_rise, bit_tick, fs_act;
  logic [HW-1:0]    low_len;

  assign gen_run  = master & gen_rst_n;
  assign fs_run   = gen_run & fs_rst_n;
  assign div_end  = (dcnt >= clk_div);
  assign ext_rise = xsync[1] & ~xsync[2];
  assign bit_tick = gen_run & (ext_clk_sel ? ext_rise : div_end);
  assign low_len  = ({1'b0, clk_div} + HW'(2)) >> 1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) xsync <= '0;
    else        xsync <= {xsync[1:0], ext_bclk_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      dcnt <= '0;
    else if (!gen_run || ext_clk_sel) dcnt <= '0;
    else if (div_end)                 dcnt <= '0;
    else                              dcnt <= dcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        bcnt <= '0;
    else if (!fs_run)  bcnt <= '0;
    else if (bit_tick) bcnt <= (bcnt >= frame_per) ? '0 : bcnt + 1'b1;

  assign fs_act   = fs_run & (bcnt <= sync_wid);
  assign bclk_out = gen_run & ~ext_clk_sel & ({1'b0, dcnt} >= low_len);
  assign bclk_oe  = master & ~ext_clk_sel;
  assign fs_oe    = master;
  assign fs_out   = fs_act ^ fs_low;

  p_div_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_run && !ext_clk_sel && div_end) |=> (dcnt == '0));

  p_gen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_run |=> (dcnt == '0 && bcnt == '0 && !bclk_out));

  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_run && bit_tick && bcnt >= frame_per) |=> (bcnt == '0));

  p_bit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_run && !bit_tick) |=> $stable(bcnt));

  p_fs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_rst_n |=> (bcnt == '0));

  p_ext_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clk_sel |-> (!bclk_oe && !bclk_out));

  p_slave_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (!bclk_oe && !fs_oe && fs_out == fs_low));

endmodule

// File: tb/frame_sync_gen_test.sv
module frame_sync_gen_test;
  localparam int CLK_P = 10;
  localparam int EXT_H = 3;

  typedef struct {int per; int wid; bit ext;} frame_t;

  logic clk = 0, rst_n = 0, master = 0, ext_clk_sel = 0, ext_bclk_in = 0;
  logic [7:0] clk_div = 8'd1;
  logic [9:0] frame_per = 10'd31, sync_wid = 10'd15;
  logic fs_low = 0, gen_rst_n = 0, fs_rst_n = 0;
  logic bclk_out, bclk_oe, fs_out, fs_oe;
  bit ext_on = 0;
  bit cur_pol = 0;
  int total = 0, bad = 0;
  frame_t q[$];

  frame_sync_gen uut (.*);

  always #(CLK_P/2) clk = ~clk;

  initial forever begin
    if (ext_on) begin
      repeat (EXT_H) @(posedge clk);
      #1 ext_bclk_in = ~ext_bclk_in;
    end else @(posedge clk);
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  function automatic bit fs_active();
    return fs_out != cur_pol;
  endfunction

  initial begin
    frame_t it;
    bit prev, now, fell;
    int hi, tot;
    forever begin
      wait (q.size() > 0);
      it = q[0];
      prev = 1;
      forever begin
        @(negedge clk);
        now = fs_active();
        if (now && !prev) break;
        prev = now;
      end
      hi = 1; tot = 1; fell = 0;
      forever begin
        @(negedge clk);
        now = fs_active();
        if (!now) fell = 1;
        if (now && fell) break;
        tot++;
        if (now && !fell) hi++;
      end
      void'(q.pop_front());
      check(it.ext ? "R8 period" : "R3 period", tot, it.per);
      check(it.ext ? "R8 width" : "R4 width", hi, it.wid);
    end
  end

  task automatic window(int n, output int bclk_hi, output int fs_on);
    bclk_hi = 0; fs_on = 0;
    repeat (n) begin
      @(negedge clk);
      if (bclk_out) bclk_hi++;
      if (fs_out != fs_low) fs_on++;
    end
  endtask

  task automatic measure_bclk(int n);
    int hi, tot;
    clk_div = 8'(n);
    repeat (3 * (n + 1)) @(negedge clk);
    while (bclk_out) @(negedge clk);
    while (!bclk_out) @(negedge clk);
    hi = 0; tot = 0;
    while (bclk_out) begin hi++; tot++; @(negedge clk); end
    while (!bclk_out) begin tot++; @(negedge clk); end
    check("R2 bclk high", hi, (n + 1) / 2);
    check("R2 bclk period", tot, n + 1);
  endtask

  task automatic run_frames(int div, int per, int wid, bit pol, bit ext, int nf);
    frame_t it;
    int unit;
    @(negedge clk);
    fs_rst_n = 0;
    clk_div = 8'(div); frame_per = 10'(per); sync_wid = 10'(wid);
    fs_low = pol; cur_pol = pol; ext_clk_sel = ext; ext_on = ext;
    repeat (20) @(negedge clk);
    fs_rst_n = 1;
    unit = ext ? 2 * EXT_H : div + 1;
    repeat ((per + 1) * unit + 4) @(negedge clk);
    it.per = (per + 1) * unit; it.wid = (wid + 1) * unit; it.ext = ext;
    repeat (nf) q.push_back(it);
    wait (q.size() == 0);
  endtask

  initial begin
    int bh, fo;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset bclk_oe", bclk_oe, 0);
    check("R1 reset fs_oe", fs_oe, 0);
    gen_rst_n = 1; fs_rst_n = 1;
    window(30, bh, fo);
    check("R1 slave bclk high cycles", bh, 0);
    check("R1 slave fs active cycles", fo, 0);
    check("R1 slave oe", {bclk_oe, fs_oe}, 0);

    master = 1; gen_rst_n = 0;
    window(30, bh, fo);
    check("R1 master oe", {bclk_oe, fs_oe}, 3);
    check("R6 bclk held", bh, 0);
    check("R6 fs held", fo, 0);

    gen_rst_n = 1; fs_rst_n = 0;
    window(40, bh, fo);
    check("R7 bclk runs", (bh > 0) ? 1 : 0, 1);
    check("R7 fs idle", fo, 0);
    check("R5 idle high level", fs_out, 0);
    fs_low = 1;
    window(10, bh, fo);
    check("R5 idle low level", fs_out, 1);
    fs_low = 0;

    measure_bclk(1);
    measure_bclk(3);
    measure_bclk(4);

    clk_div = 8'd3; sync_wid = 10'd2; frame_per = 10'd9;
    @(negedge clk);
    fs_rst_n = 1;
    #1 check("R7 active at release", fs_out, 1);

    run_frames(1, 31, 15, 0, 0, 2);
    run_frames(3, 7, 0, 1, 0, 2);
    run_frames(2, 15, 7, 0, 0, 1);
    run_frames(0, 9, 2, 1, 0, 2);
    run_frames(0, 5, 1, 0, 1, 2);
    check("R8 bclk_oe", bclk_oe, 0);
    check("R8 fs_oe", fs_oe, 1);
    window(20, bh, fo);
    check("R8 bclk_out low", bh, 0);
    report();
  end
endmodule